// File: doc/BRIEF.md
# ADC Channel Read Sequencer

This block runs one complete read transaction against a four-channel analog-to-digital converter on an I2C bus. It sits above a byte-level bus controller and talks to it through a command/response handshake: it issues one command at a time (start with address, write byte, repeated start with address, read with acknowledge, read with acknowledge withheld, stop, flush read, re-initialise), and it waits for the controller to report completion along with any acknowledge, bus-error or arbitration flags.

A request carries the three device address bits, the channel, the input mode, the auto-increment flag, the analog output enable and the number of samples wanted. The sequencer addresses the converter for writing and sends the control byte. It then turns the bus around with a repeated start in read direction rather than a stop. Two bytes are read and dropped: the address echo that the controller returns, and the stale conversion that the converter sends first. The remaining bytes come out on a valid/data stream, and the final one is flagged. Each request ends with a single-cycle done pulse and a fail flag.

Top module: `i2c_adc_reader`

## Requirements
- R1: After reset and between requests, busy, cmd_valid, done and smp_valid are all 0.
- R2: A request with byte_count N>0 first issues op 0 (start) with data {4'b1001, dev_sel, 1'b0}, then op 1 (write) with the control byte: bit 6 = aout_en, bits 5:4 = in_mode, bit 2 = auto_inc, bits 1:0 = chan, bits 7 and 3 zero.
- R3: After the control byte the next command is op 2 (repeated start) with data {4'b1001, dev_sel, 1'b1}; no op 5 (stop) comes between them.
- R4: The two reads after the repeated start are op 3 (read with ack) and produce no sample.
- R5: On success the block then issues N-1 op 3 reads, one op 4 (read with ack withheld), then op 5 (stop) and op 6 (flush read). Each data read result is delivered on smp_data in order, smp_last is 1 only on the Nth sample, and done rises with fail=0.
- R6: A no-acknowledge on the op 0 address or on the op 1 control byte is followed by op 5 (stop) and then done with fail=1. No other command is issued.
- R7: A no-acknowledge on the op 2 repeated start is followed by op 5 (stop), then op 6 (flush read), then done with fail=1. No sample is delivered.
- R8: A bus error or lost arbitration on any op 0 to op 4 command is followed by op 7 (re-initialise) and done with fail=1, with no stop issued.
- R9: If a command sees no cmd_done for MAX_WAIT cycles, it is abandoned in its MAX_WAIT-th cycle. cmd_valid drops, done rises with fail=1, and no further command is issued.
- R10: A request with byte_count 0 gives done with fail=1 in the cycle after it is accepted, and it issues no command.
- R11: A start pulse while busy is ignored, and the running transaction completes unchanged.
- R12: While a command waits for cmd_done, cmd_valid, cmd_op and cmd_data stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, accepted when idle |
| dev_sel | input | 3 | Device address bits appended to base 1001 |
| chan | input | 2 | Converter channel |
| in_mode | input | 2 | Analog input mode |
| auto_inc | input | 1 | Channel auto-increment flag |
| aout_en | input | 1 | Analog output enable |
| byte_count | input | CNT_W | Number of samples wanted |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-request pulse |
| fail | output | 1 | Failure status, valid with done |
| smp_valid | output | 1 | Sample strobe |
| smp_data | output | 8 | Sample byte |
| smp_last | output | 1 | Final sample of the request |
| cmd_valid | output | 1 | Command to controller is pending |
| cmd_op | output | 3 | Command code 0..7 |
| cmd_data | output | 8 | Address or write byte of the command |
| cmd_done | input | 1 | Controller finished the pending command |
| rsp_data | input | 8 | Byte returned by a read command |
| rsp_nack | input | 1 | No acknowledge seen |
| rsp_berr | input | 1 | Bus error seen |
| rsp_lab | input | 1 | Arbitration lost |

## Verification
The case that is hardest to reach from the ports is the failed turnaround. The control byte must already have been acknowledged, and only the repeated-start address then goes unacknowledged or hits a bus fault. That is the one path that needs the stop-then-flush recovery. The bench's controller model counts completed commands and injects a chosen fault on a chosen command index, so the fault lands on exactly the repeated start, or on the first data read after both discards. The timeout case uses the same model, which holds back cmd_done on the opening command and counts the cycles until the block gives up.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
   typedef enum logic [2:0] {
      OP_START   = 3'd0,
      OP_WRITE   = 3'd1,
      OP_RSTART  = 3'd2,
      OP_READ    = 3'd3,
      OP_READ_NA = 3'd4,
      OP_STOP    = 3'd5,
      OP_FLUSH   = 3'd6,
      OP_REINIT  = 3'd7
   } bus_op_e;

   typedef enum logic [3:0] {
      ST_IDLE, ST_ADDR_W, ST_CTRL, ST_RSTART, ST_SKIP0, ST_SKIP1,
      ST_DATA, ST_LAST, ST_STOP_OK, ST_FLUSH_OK, ST_STOP_FAIL,
      ST_STOP_NF, ST_FLUSH_FAIL, ST_REINIT, ST_END
   } seq_state_e;
endpackage

// File: rtl/adc_rd_ctrl_byte.sv
module adc_rd_ctrl_byte #(
   parameter logic [3:0] DEV_BASE = 4'b1001,
   parameter int         SEL_W    = 3
) (
   input  logic [SEL_W-1:0] dev_sel,
   input  logic [1:0]       chan,
   input  logic [1:0]       in_mode,
   input  logic             auto_inc,
   input  logic             aout_en,
   output logic [7:0]       addr_wr,
   output logic [7:0]       addr_rd,
   output logic [7:0]       ctrl
);
   localparam int BASE_W = 7 - SEL_W;

   generate
      if (SEL_W != 3) begin : g_bad_sel
         $error("adc_rd_ctrl_byte: SEL_W must be 3");
      end
   endgenerate

   assign addr_wr = {DEV_BASE[BASE_W-1:0], dev_sel, 1'b0};
   assign addr_rd = {DEV_BASE[BASE_W-1:0], dev_sel, 1'b1};
   assign ctrl    = {1'b0, aout_en, in_mode, 1'b0, auto_inc, chan};
endmodule

// File: rtl/adc_rd_wait_timer.sv
module adc_rd_wait_timer #(
   parameter int MAX_WAIT = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cmd_valid,
   input  logic cmd_done,
   output logic expire
);
   localparam int TW = $clog2(MAX_WAIT + 1);

   generate
      if (MAX_WAIT < 2) begin : g_bad_wait
         $error("adc_rd_wait_timer: MAX_WAIT must be at least 2");
      end
   endgenerate

   logic [TW-1:0] wait_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      wait_cnt <= '0;
      else if (!cmd_valid || cmd_done) wait_cnt <= '0;
      else                             wait_cnt <= wait_cnt + 1'b1;
   end

   assign expire = cmd_valid && !cmd_done && (wait_cnt == TW'(MAX_WAIT - 1));

   AST_TMO_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> !cmd_valid) else $error("timeout did not drop command"); // R9
endmodule

// File: rtl/adc_rd_sample_reg.sv
module adc_rd_sample_reg #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_last,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic              out_last
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
         out_last  <= 1'b0;
      end else begin
         out_valid <= in_valid;
         out_last  <= in_valid && in_last;
         if (in_valid) out_data <= in_data;
      end
   end

   AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |-> out_valid) else $error("last without valid"); // R5
endmodule

// File: rtl/i2c_adc_reader.sv
module i2c_adc_reader
   import adc_rd_pkg::*;
#(
   parameter int         CNT_W    = 8,
   parameter int         MAX_WAIT = 100,
   parameter logic [3:0] DEV_BASE = 4'b1001
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [2:0]       dev_sel,
   input  logic [1:0]       chan,
   input  logic [1:0]       in_mode,
   input  logic             auto_inc,
   input  logic             aout_en,
   input  logic [CNT_W-1:0] byte_count,
   output logic             busy,
   output logic             done,
   output logic             fail,
   output logic             smp_valid,
   output logic [7:0]       smp_data,
   output logic             smp_last,
   output logic             cmd_valid,
   output logic [2:0]       cmd_op,
   output logic [7:0]       cmd_data,
   input  logic             cmd_done,
   input  logic [7:0]       rsp_data,
   input  logic             rsp_nack,
   input  logic             rsp_berr,
   input  logic             rsp_lab
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
   localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

   generate
      if (CNT_W < 2) begin : g_bad_cnt
         $error("i2c_adc_reader: CNT_W must be at least 2");
      end
   endgenerate

   seq_state_e       state_q, state_d;
   logic [CNT_W-1:0] left_q;
   logic             fail_q, set_fail, accept;
   logic [7:0]       addr_wr, addr_rd, ctrl;
   logic [7:0]       addr_wr_q, addr_rd_q, ctrl_q;
   logic             tmo_expire, bus_bad, emit;
   bus_op_e          op_c;

   adc_rd_ctrl_byte #(.DEV_BASE(DEV_BASE), .SEL_W(3)) u_compose (
      .dev_sel(dev_sel), .chan(chan), .in_mode(in_mode),
      .auto_inc(auto_inc), .aout_en(aout_en),
      .addr_wr(addr_wr), .addr_rd(addr_rd), .ctrl(ctrl)
   );

   adc_rd_wait_timer #(.MAX_WAIT(MAX_WAIT)) u_timer (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid),
      .cmd_done(cmd_done), .expire(tmo_expire)
   );

   assign accept  = (state_q == ST_IDLE) && start;
   assign bus_bad = rsp_berr || rsp_lab;

   // command presented to the controller, decoded from the step
   always_comb begin
      cmd_valid = 1'b1;
      cmd_data  = 8'h00;
      op_c      = OP_READ;
      unique case (state_q)
         ST_ADDR_W:               begin op_c = OP_START;  cmd_data = addr_wr_q; end
         ST_CTRL:                 begin op_c = OP_WRITE;  cmd_data = ctrl_q;    end
         ST_RSTART:               begin op_c = OP_RSTART; cmd_data = addr_rd_q; end
         ST_SKIP0, ST_SKIP1,
         ST_DATA:                 op_c = OP_READ;
         ST_LAST:                 op_c = OP_READ_NA;
         ST_STOP_OK, ST_STOP_FAIL,
         ST_STOP_NF:              op_c = OP_STOP;
         ST_FLUSH_OK,
         ST_FLUSH_FAIL:           op_c = OP_FLUSH;
         ST_REINIT:               op_c = OP_REINIT;
         default:                 cmd_valid = 1'b0;
      endcase
   end
   assign cmd_op = op_c;

   // step sequencing
   always_comb begin
      state_d  = state_q;
      set_fail = 1'b0;
      if (state_q == ST_IDLE) begin
         if (start) begin
            if (byte_count == '0) begin
               state_d  = ST_END;
               set_fail = 1'b1;
            end else begin
               state_d = ST_ADDR_W;
            end
         end
      end else if (state_q == ST_END) begin
         state_d = ST_IDLE;
      end else if (tmo_expire) begin
         state_d  = ST_END;
         set_fail = 1'b1;
      end else if (cmd_done) begin
         unique case (state_q)
            ST_ADDR_W, ST_CTRL: begin
               if (bus_bad)       begin state_d = ST_REINIT;    set_fail = 1'b1; end
               else if (rsp_nack) begin state_d = ST_STOP_FAIL; set_fail = 1'b1; end
               else state_d = (state_q == ST_ADDR_W) ? ST_CTRL : ST_RSTART;
            end
            ST_RSTART: begin
               if (bus_bad)       begin state_d = ST_REINIT;  set_fail = 1'b1; end
               else if (rsp_nack) begin state_d = ST_STOP_NF; set_fail = 1'b1; end
               else state_d = ST_SKIP0;
            end
            ST_SKIP0, ST_SKIP1, ST_DATA, ST_LAST: begin
               if (bus_bad) begin
                  state_d  = ST_REINIT;
                  set_fail = 1'b1;
               end else begin
                  unique case (state_q)
                     ST_SKIP0: state_d = ST_SKIP1;
                     ST_SKIP1: state_d = (left_q == ONE) ? ST_LAST : ST_DATA;
                     ST_DATA:  state_d = (left_q == TWO) ? ST_LAST : ST_DATA;
                     default:  state_d = ST_STOP_OK;
                  endcase
               end
            end
            ST_STOP_OK:    state_d = ST_FLUSH_OK;
            ST_STOP_NF:    state_d = ST_FLUSH_FAIL;
            default:       state_d = ST_END;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         left_q    <= '0;
         fail_q    <= 1'b0;
         addr_wr_q <= '0;
         addr_rd_q <= '0;
         ctrl_q    <= '0;
      end else begin
         state_q <= state_d;
         if (set_fail)    fail_q <= 1'b1;
         else if (accept) fail_q <= 1'b0;
         if (accept) begin
            left_q    <= byte_count;
            addr_wr_q <= addr_wr;
            addr_rd_q <= addr_rd;
            ctrl_q    <= ctrl;
         end else if (state_q == ST_DATA && cmd_done && !bus_bad) begin
            left_q <= left_q - 1'b1;
         end
      end
   end

   assign emit = cmd_done && !bus_bad && (state_q == ST_DATA || state_q == ST_LAST);

   adc_rd_sample_reg #(.DATA_W(8)) u_out (
      .clk(clk), .rst_n(rst_n), .in_valid(emit), .in_data(rsp_data),
      .in_last(state_q == ST_LAST),
      .out_valid(smp_valid), .out_data(smp_data), .out_last(smp_last)
   );

   assign busy = (state_q != ST_IDLE);
   assign done = (state_q == ST_END);
   assign fail = done && fail_q;

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !cmd_valid && !smp_valid) else $error("activity while idle"); // R1
   AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !cmd_done && !tmo_expire |=>
         cmd_valid && $stable(cmd_op) && $stable(cmd_data)) else $error("command changed"); // R12
   AST_ZERO_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && start && byte_count == '0 |=> done && fail && !cmd_valid) else $error("zero size"); // R10
   AST_NACK_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_done && rsp_nack && !bus_bad && cmd_op <= 3'd2 |=>
         cmd_valid && cmd_op == 3'd5) else $error("no stop after nack"); // R6
   AST_FAULT_REINIT: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_done && bus_bad && cmd_op <= 3'd4 |=>
         cmd_valid && cmd_op == 3'd7) else $error("no reinit after fault"); // R8
endmodule

// File: tb/i2c_adc_reader_bench.sv
`timescale 1ns/1ps
module i2c_adc_reader_bench;
   localparam int MAXW = 100;
   localparam logic [2:0] C_START = 3'd0, C_WRITE = 3'd1, C_RSTART = 3'd2, C_READ = 3'd3,
                          C_READ_NA = 3'd4, C_STOP = 3'd5, C_FLUSH = 3'd6, C_REINIT = 3'd7;

   logic clk = 1'b0, rst_n = 1'b0;
   logic start = 1'b0;
   logic [2:0] dev_sel = '0;
   logic [1:0] chan = '0, in_mode = '0;
   logic auto_inc = 1'b0, aout_en = 1'b0;
   logic [7:0] byte_count = '0;
   logic busy, done, fail, smp_valid, smp_last, cmd_valid;
   logic [7:0] smp_data, cmd_data;
   logic [2:0] cmd_op;
   logic cmd_done = 1'b0, rsp_nack = 1'b0, rsp_berr = 1'b0, rsp_lab = 1'b0;
   logic [7:0] rsp_data = '0;

   always #4 clk = ~clk;

   i2c_adc_reader u_i2c_adc_reader (
      .clk(clk), .rst_n(rst_n), .start(start), .dev_sel(dev_sel), .chan(chan),
      .in_mode(in_mode), .auto_inc(auto_inc), .aout_en(aout_en), .byte_count(byte_count),
      .busy(busy), .done(done), .fail(fail), .smp_valid(smp_valid), .smp_data(smp_data),
      .smp_last(smp_last), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
      .cmd_done(cmd_done), .rsp_data(rsp_data), .rsp_nack(rsp_nack),
      .rsp_berr(rsp_berr), .rsp_lab(rsp_lab)
   );

   int total = 0, bad = 0;
   logic [2:0] lg_op [64];
   logic [7:0] lg_dat[64];
   logic [7:0] sm_dat[64];
   logic       sm_last[64];
   int n_cmd = 0, n_smp = 0, rd_cnt = 0, hang_cyc = 0, hold_err = 0;
   int flt_idx = -1, flt_kind = 0, rdelay = 3;
   logic got_fail;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // controller model
   initial begin
      int wcnt = 0;
      logic [2:0] h_op = '0;
      logic [7:0] h_dat = '0;
      forever begin
         @(negedge clk);
         if (cmd_done) begin
            cmd_done = 1'b0; rsp_nack = 1'b0; rsp_berr = 1'b0; rsp_lab = 1'b0;
            wcnt = 0;
         end else if (cmd_valid) begin
            if (flt_kind == 4 && n_cmd == flt_idx) begin
               hang_cyc++;
            end else begin
               wcnt++;
               if (wcnt == 1) begin h_op = cmd_op; h_dat = cmd_data; end
               else if (h_op != cmd_op || h_dat != cmd_data) hold_err++;
               if (wcnt >= rdelay) begin
                  lg_op[n_cmd] = cmd_op; lg_dat[n_cmd] = cmd_data;
                  if (cmd_op == C_READ || cmd_op == C_READ_NA) begin
                     rsp_data = 8'hA0 + 8'(rd_cnt); rd_cnt++;
                  end
                  if (n_cmd == flt_idx) begin
                     rsp_nack = (flt_kind == 1); rsp_berr = (flt_kind == 2);
                     rsp_lab  = (flt_kind == 3);
                  end
                  n_cmd++;
                  cmd_done = 1'b1;
               end
            end
         end
      end
   end

   // sample monitor
   initial forever begin
      @(negedge clk);
      if (smp_valid) begin
         sm_dat[n_smp] = smp_data; sm_last[n_smp] = smp_last; n_smp++;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   task automatic run_txn(input logic [2:0] s, input logic [1:0] c, input logic [1:0] m,
                          input logic a, input logic o, input logic [7:0] n);
      n_cmd = 0; n_smp = 0; rd_cnt = 0; hang_cyc = 0;
      @(negedge clk);
      dev_sel = s; chan = c; in_mode = m; auto_inc = a; aout_en = o; byte_count = n;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (!done) @(negedge clk);
      got_fail = fail;
      @(negedge clk);
   endtask

   task automatic t_reset;
      chk(!busy && !cmd_valid && !done && !smp_valid, "R1 reset quiet",
          {busy, cmd_valid, done, smp_valid}, 0);
   endtask

   task automatic t_read(input logic [2:0] s, input logic [1:0] c, input logic [1:0] m,
                         input logic a, input logic o, input logic [7:0] n, input int d);
      int ncount;
      rdelay = d; flt_idx = -1; flt_kind = 0; hold_err = 0;
      run_txn(s, c, m, a, o, n);
      ncount = int'(n);
      chk(lg_op[0] == C_START && lg_dat[0] == {4'b1001, s, 1'b0}, "R2 address write",
          lg_dat[0], {4'b1001, s, 1'b0});
      chk(lg_op[1] == C_WRITE && lg_dat[1] == {1'b0, o, m, 1'b0, a, c}, "R2 control byte",
          lg_dat[1], {1'b0, o, m, 1'b0, a, c});
      chk(lg_op[2] == C_RSTART && lg_dat[2] == {4'b1001, s, 1'b1}, "R3 repeated start",
          {lg_op[2], lg_dat[2]}, {C_RSTART, 4'b1001, s, 1'b1});
      chk(lg_op[3] == C_READ && lg_op[4] == C_READ, "R4 two discard reads",
          {lg_op[3], lg_op[4]}, {C_READ, C_READ});
      for (int i = 0; i < ncount - 1; i++)
         chk(lg_op[5 + i] == C_READ, "R5 data read op", lg_op[5 + i], C_READ);
      chk(lg_op[4 + ncount] == C_READ_NA && lg_op[5 + ncount] == C_STOP &&
          lg_op[6 + ncount] == C_FLUSH, "R5 final read/stop/flush",
          {lg_op[4 + ncount], lg_op[5 + ncount], lg_op[6 + ncount]},
          {C_READ_NA, C_STOP, C_FLUSH});
      chk(n_cmd == ncount + 7, "R5 command count", n_cmd, ncount + 7);
      chk(n_smp == ncount, "R4 sample count excludes discards", n_smp, ncount);
      for (int i = 0; i < ncount; i++)
         chk(sm_dat[i] == 8'hA2 + 8'(i) && sm_last[i] == (i == ncount - 1),
             "R5 sample value/last", {sm_last[i], sm_dat[i]},
             {(i == ncount - 1), 8'hA2 + 8'(i)});
      chk(!got_fail, "R5 success status", got_fail, 0);
      chk(hold_err == 0, "R12 command stable while waiting", hold_err, 0);
   endtask

   task automatic t_fault(input int idx, input int kind, input logic [7:0] n,
                          input int exp_cmds, input logic [2:0] tail0,
                          input logic [2:0] tail1, input int ntail, input string tag);
      rdelay = 2; flt_idx = idx; flt_kind = kind;
      run_txn(3'd5, 2'd1, 2'd2, 1'b1, 1'b0, n);
      chk(got_fail, {tag, " fail flag"}, got_fail, 1);
      chk(n_cmd == exp_cmds, {tag, " command count"}, n_cmd, exp_cmds);
      chk(lg_op[idx + 1] == tail0, {tag, " first recovery op"}, lg_op[idx + 1], tail0);
      if (ntail > 1)
         chk(lg_op[idx + 2] == tail1, {tag, " second recovery op"}, lg_op[idx + 2], tail1);
      chk(n_smp == 0, {tag, " no samples"}, n_smp, 0);
      flt_idx = -1; flt_kind = 0;
   endtask

   task automatic t_timeout;
      rdelay = 2; flt_idx = 0; flt_kind = 4;
      run_txn(3'd2, 2'd0, 2'd0, 1'b0, 1'b0, 8'd2);
      chk(got_fail, "R9 timeout fails", got_fail, 1);
      chk(hang_cyc == MAXW, "R9 wait window", hang_cyc, MAXW);
      chk(n_cmd == 0, "R9 no stop issued", n_cmd, 0);
      repeat (5) @(negedge clk);
      chk(!cmd_valid && !busy, "R9 idle after timeout", {cmd_valid, busy}, 0);
      flt_idx = -1; flt_kind = 0;
   endtask

   task automatic t_zero;
      n_cmd = 0; n_smp = 0;
      @(negedge clk);
      byte_count = 8'd0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(done && fail, "R10 zero size rejected next cycle", {done, fail}, 2'b11);
      repeat (4) @(negedge clk);
      chk(n_cmd == 0 && !cmd_valid, "R10 no bus activity", n_cmd, 0);
   endtask

   task automatic t_busy_ignore;
      rdelay = 2; flt_idx = -1; flt_kind = 0;
      n_cmd = 0; n_smp = 0; rd_cnt = 0;
      @(negedge clk);
      dev_sel = 3'd1; chan = 2'd2; in_mode = 2'd0; auto_inc = 1'b0; aout_en = 1'b0;
      byte_count = 8'd2; start = 1'b1;
      @(negedge clk); start = 1'b0;
      repeat (3) @(negedge clk);
      dev_sel = 3'd6; byte_count = 8'd0; start = 1'b1;
      @(negedge clk); start = 1'b0;
      while (!done) @(negedge clk);
      got_fail = fail;
      repeat (20) @(negedge clk);
      chk(!got_fail && n_cmd == 9 && n_smp == 2, "R11 start ignored while busy",
          n_cmd, 9);
      chk(lg_dat[2] == {4'b1001, 3'd1, 1'b1}, "R11 address unchanged", lg_dat[2],
          {4'b1001, 3'd1, 1'b1});
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset;
      t_read(3'd0, 2'd0, 2'd0, 1'b0, 1'b0, 8'd1, 1);
      t_read(3'd7, 2'd3, 2'd1, 1'b1, 1'b1, 8'd3, 4);
      t_read(3'd4, 2'd1, 2'd3, 1'b0, 1'b1, 8'd5, 2);
      t_fault(0, 1, 8'd2, 2, C_STOP, C_STOP, 1, "R6 address nack");
      t_fault(1, 1, 8'd2, 3, C_STOP, C_STOP, 1, "R6 control nack");
      t_fault(2, 1, 8'd2, 5, C_STOP, C_FLUSH, 2, "R7 turnaround nack");
      t_fault(2, 2, 8'd2, 4, C_REINIT, C_REINIT, 1, "R8 bus error on turnaround");
      t_fault(5, 3, 8'd3, 7, C_REINIT, C_REINIT, 1, "R8 lost arbitration on read");
      t_timeout;
      t_zero;
      t_busy_ignore;
      t_reset;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule